// File: doc/BRIEF.md
# Vertical Polyphase Line Scaler

This block resizes one video component in the vertical direction. It collects incoming lines of 8-bit samples into a five-line store. For each column it combines the samples of three or five neighbouring lines with an eight-phase polyphase FIR, and it emits 10-bit samples that are clipped to full or reduced range. A fractional line position advances by a programmable step after every output line. That step sets the ratio between input and output lines, so the same block both enlarges and shrinks the image.

A frame opens with a one-cycle start pulse while the configuration is stable. Input lines then arrive pixel by pixel under a valid/ready handshake, and the final pixel of the final line carries an end-of-frame flag. Output pixels come out one per cycle with an end-of-line marker, and the block returns to idle after the requested number of output lines. Two coefficient banks are supplied, and a component select picks the luma or the chroma bank so that Y and Cb/Cr can use different filters.

Top module: `vline_polyphase_scaler`

## Requirements
- R1: After reset, and until a frame start arrives, `out_valid` and `in_ready` are both 0.
- R2: Each output sample is the clipped value of floor((S + 16) / 32), where S is the sum of coefficient × input sample over the active taps. Coefficient k of phase p sits at bits [8*(5*p+k) +: 8] of the selected bank.
- R3: With `cfg_five_tap`=1, all five taps are used. Tap k (0..4) multiplies the line at offset k-2 from the centre line, and a negative offset means an older line.
- R4: With `cfg_five_tap`=0, only taps k=1, 2 and 3 take part, with the same line offsets as in R3. Taps 0 and 4 have no effect.
- R5: Tap 2 (the centre) is read as an unsigned 0..255 value. All other taps are 8-bit two's complement.
- R6: The line position holds a 10-bit fraction that is 0 at frame start, and the phase is fraction bits [9:7]. After each output line, `cfg_step` (11 bits, units of 1/1024 line) is added. The carry out of the fraction gives the number of new input lines to fetch (0 to 2), and the centre moves forward by that many lines.
- R7: The first output line is centred on input line 0. Taps that reach above line 0 see line 0.
- R8: Once the line flagged with `in_eof` has been taken, further fetches repeat the last line. Taps that reach past it see the last line, and `in_ready` stays 0.
- R9: With `cfg_full_range`=1, outputs are clipped to [0,1023]. With it 0, outputs are clipped to [64,960].
- R10: `cfg_chroma`=1 selects `coef_chroma`; `cfg_chroma`=0 selects `coef_luma`.
- R11: Each output line is LINE_W consecutive `out_valid` cycles, with `out_eol` set on the last one and at least one idle cycle after it. Exactly `cfg_out_lines` lines are produced, after which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes the input sample this cycle |
| in_pix | input | 8 | Input sample |
| in_eof | input | 1 | Marks the last pixel of the last input line |
| cfg_five_tap | input | 1 | 1 = five taps, 0 = three taps |
| cfg_full_range | input | 1 | 1 = clip to [0,1023], 0 = clip to [64,960] |
| cfg_chroma | input | 1 | Selects the chroma coefficient bank |
| cfg_step | input | 11 | Line position step per output line, in 1/1024 lines |
| cfg_out_lines | input | OUT_LINES_W | Output lines per frame (at least 1) |
| coef_luma | input | 320 | Luma bank: 8 phases × 5 taps × 8 bits |
| coef_chroma | input | 320 | Chroma bank, same layout |
| out_valid | output | 1 | Output sample present |
| out_pix | output | 10 | Output sample |
| out_eol | output | 1 | Last sample of an output line |

## Verification
The bench sweeps both tap counts, both clip ranges, both banks, four steps and three input frame heights, and compares every output sample with an arithmetic model. The corner cases are frames shorter than the filter window, where a wrong top-of-frame fill would mix stale store contents into the first lines, and downscaling past the last line, where a missing repeat would stall the block or read old data. The luma bank uses arbitrary coefficients, so the sums often go negative or overflow. This exposes a clip bound that is off by one, a signed centre tap, and rounding by truncation instead of floor-with-bias. The bench also watches for a wrong `out_eol` position and for output that continues after the requested line count.

// File: rtl/vlps_pkg.sv
package vlps_pkg;
  localparam int NTAP    = 5;   // line taps held in the store
  localparam int NPHASE  = 8;   // polyphase phases
  localparam int PH_W    = 3;   // phase index width
  localparam int CW      = 8;   // coefficient width
  localparam int PW      = 8;   // input sample width
  localparam int OW      = 10;  // output sample width
  localparam int FRAC_W  = 10;  // fractional line position width
  localparam int STEP_W  = FRAC_W + 1;
  localparam int BANK_W  = NTAP * NPHASE * CW;
  localparam int UNITY_B = 7;   // coefficients for unity gain sum to 2**UNITY_B
  localparam int SHIFT   = UNITY_B - (OW - PW);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_EMIT
  } vlps_state_e;
endpackage

// File: rtl/vlps_line_store.sv
module vlps_line_store
  import vlps_pkg::*;
#(
  parameter int LINE_W = 16,
  localparam int XW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      fill_all,
  input  logic [XW-1:0]             wr_col,
  input  logic [PW-1:0]             wr_data,
  input  logic                      rep_en,
  input  logic [XW-1:0]             rd_col,
  output logic [NTAP-1:0][PW-1:0]   rd_taps
);
  // slot 0 is the oldest line, slot NTAP-1 the newest
  logic [PW-1:0] mem [NTAP][LINE_W];

  always_ff @(posedge clk) begin
    for (int c = 0; c < LINE_W; c++) begin
      if (rep_en) begin
        for (int k = 0; k < NTAP-1; k++) mem[k][c] <= mem[k+1][c];
      end else if (wr_en && wr_col == XW'(c)) begin
        if (fill_all) begin
          for (int k = 0; k < NTAP; k++) mem[k][c] <= wr_data;
        end else begin
          for (int k = 0; k < NTAP-1; k++) mem[k][c] <= mem[k+1][c];
          mem[NTAP-1][c] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NTAP; k++) rd_taps[k] = mem[k][rd_col];
  end

  AST_PRIME_FILL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill_all && wr_col == '0) |=>
      (mem[0][0] == $past(wr_data) && mem[2][0] == $past(wr_data) &&
       mem[NTAP-1][0] == $past(wr_data)));  // R7

  AST_REPEAT_DUP: assert property (@(posedge clk) disable iff (rst)
    rep_en |=> (mem[NTAP-1][0] == mem[NTAP-2][0]));  // R8
endmodule

// File: rtl/vlps_fir_column.sv
module vlps_fir_column
  import vlps_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     eol_in,
  input  logic                     five_tap,
  input  logic                     full_range,
  input  logic [PH_W-1:0]          phase,
  input  logic [BANK_W-1:0]        bank,
  input  logic [NTAP-1:0][PW-1:0]  taps,
  output logic                     out_valid,
  output logic [OW-1:0]            out_pix,
  output logic                     out_eol
);
  localparam int PRW = CW + PW + 2;
  localparam int ACW = PRW + $clog2(NTAP);
  localparam int SW  = ACW - SHIFT;
  localparam int CTR = NTAP / 2;

  // in three-tap mode the centre sits one slot newer
  logic [NTAP-1:0][PW-1:0] taps_up;
  assign taps_up = {PW'(0), taps[NTAP-1:1]};

  logic [CW-1:0]           cf_v;
  logic signed [CW:0]      cf_s;
  logic [PW-1:0]           px_v;
  logic signed [PRW-1:0]   prod_v;
  logic signed [ACW-1:0]   acc;

  always_comb begin
    acc    = '0;
    cf_v   = '0;
    cf_s   = '0;
    px_v   = '0;
    prod_v = '0;
    for (int k = 0; k < NTAP; k++) begin
      cf_v   = bank[(int'(phase) * NTAP + k) * CW +: CW];
      cf_s   = (k == CTR) ? $signed({1'b0, cf_v}) : $signed({cf_v[CW-1], cf_v});
      px_v   = five_tap ? taps[k] : taps_up[k];
      prod_v = cf_s * $signed({1'b0, px_v});
      if (five_tap || (k != 0 && k != NTAP-1)) acc = acc + ACW'(prod_v);
    end
  end

  logic signed [ACW-1:0] rnd;
  logic signed [SW-1:0]  shv;
  logic signed [SW-1:0]  lo_s, hi_s;
  logic [OW-1:0]         clipped;

  assign rnd  = acc + $signed(ACW'(1 << (SHIFT-1)));
  assign shv  = rnd[ACW-1:SHIFT];
  assign lo_s = full_range ? SW'(0) : SW'(64);
  assign hi_s = full_range ? SW'((1 << OW) - 1) : SW'(960);

  always_comb begin
    if (shv < lo_s)      clipped = lo_s[OW-1:0];
    else if (shv > hi_s) clipped = hi_s[OW-1:0];
    else                 clipped = shv[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= en;
      out_eol   <= en && eol_in;
      if (en) out_pix <= clipped;
    end
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(full_range)) |-> (out_pix >= OW'(64) && out_pix <= OW'(960)));  // R9
endmodule

// File: rtl/vlps_ctrl.sv
module vlps_ctrl
  import vlps_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int OUT_LINES_W = 12,
  localparam int XW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   in_valid,
  input  logic                   in_eof,
  input  logic                   five_tap,
  input  logic [STEP_W-1:0]      step,
  input  logic [OUT_LINES_W-1:0] out_lines,
  output logic                   in_ready,
  output logic                   wr_en,
  output logic                   fill_all,
  output logic                   rep_en,
  output logic [XW-1:0]          col_o,
  output logic                   emit,
  output logic                   emit_eol,
  output logic [PH_W-1:0]        phase
);
  vlps_state_e            st;
  logic [XW-1:0]          col;
  logic [FRAC_W-1:0]      frac;
  logic [1:0]             need;
  logic                   eof_seen, first;
  logic [OUT_LINES_W-1:0] done_cnt;
  logic                   col_last;
  logic [FRAC_W+1:0]      adv;

  assign col_last = (col == XW'(LINE_W - 1));
  assign adv      = {2'b00, frac} + {1'b0, step};
  assign in_ready = (st == ST_FILL) && (need != 2'd0) && !eof_seen;
  assign wr_en    = in_ready && in_valid;
  assign fill_all = first;
  assign rep_en   = (st == ST_FILL) && (need != 2'd0) && eof_seen;
  assign emit     = (st == ST_EMIT);
  assign emit_eol = emit && col_last;
  assign col_o    = col;
  assign phase    = frac[FRAC_W-1 -: PH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      col      <= '0;
      frac     <= '0;
      need     <= '0;
      eof_seen <= 1'b0;
      first    <= 1'b0;
      done_cnt <= '0;
    end else if (frame_start) begin
      st       <= ST_FILL;
      col      <= '0;
      frac     <= '0;
      need     <= five_tap ? 2'd3 : 2'd2;
      eof_seen <= 1'b0;
      first    <= 1'b1;
      done_cnt <= '0;
    end else begin
      case (st)
        ST_FILL: begin
          if (need == 2'd0) begin
            st  <= ST_EMIT;
            col <= '0;
          end else if (eof_seen) begin
            need <= need - 2'd1;
          end else if (in_valid) begin
            if (col_last) begin
              col   <= '0;
              need  <= need - 2'd1;
              first <= 1'b0;
              if (in_eof) eof_seen <= 1'b1;
            end else begin
              col <= col + XW'(1);
            end
          end
        end
        ST_EMIT: begin
          if (col_last) begin
            col      <= '0;
            done_cnt <= done_cnt + OUT_LINES_W'(1);
            if (done_cnt + OUT_LINES_W'(1) == out_lines) begin
              st <= ST_IDLE;
            end else begin
              st   <= ST_FILL;
              frac <= adv[FRAC_W-1:0];
              need <= adv[FRAC_W+1:FRAC_W];
            end
          end else begin
            col <= col + XW'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vline_polyphase_scaler.sv
module vline_polyphase_scaler
  import vlps_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int OUT_LINES_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PW-1:0]          in_pix,
  input  logic                   in_eof,
  input  logic                   cfg_five_tap,
  input  logic                   cfg_full_range,
  input  logic                   cfg_chroma,
  input  logic [STEP_W-1:0]      cfg_step,
  input  logic [OUT_LINES_W-1:0] cfg_out_lines,
  input  logic [BANK_W-1:0]      coef_luma,
  input  logic [BANK_W-1:0]      coef_chroma,
  output logic                   out_valid,
  output logic [OW-1:0]          out_pix,
  output logic                   out_eol
);
  localparam int XW = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  logic                    wr_en, fill_all, rep_en, emit, emit_eol;
  logic [XW-1:0]           col;
  logic [PH_W-1:0]         phase;
  logic [NTAP-1:0][PW-1:0] taps;
  logic [BANK_W-1:0]       bank;

  assign bank = cfg_chroma ? coef_chroma : coef_luma;

  vlps_ctrl #(.LINE_W(LINE_W), .OUT_LINES_W(OUT_LINES_W)) ctrl_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
    .in_eof(in_eof), .five_tap(cfg_five_tap), .step(cfg_step),
    .out_lines(cfg_out_lines), .in_ready(in_ready), .wr_en(wr_en),
    .fill_all(fill_all), .rep_en(rep_en), .col_o(col), .emit(emit),
    .emit_eol(emit_eol), .phase(phase)
  );

  vlps_line_store #(.LINE_W(LINE_W)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .fill_all(fill_all), .wr_col(col),
    .wr_data(in_pix), .rep_en(rep_en), .rd_col(col), .rd_taps(taps)
  );

  vlps_fir_column fir_i (
    .clk(clk), .rst(rst), .en(emit), .eol_in(emit_eol),
    .five_tap(cfg_five_tap), .full_range(cfg_full_range), .phase(phase),
    .bank(bank), .taps(taps), .out_valid(out_valid), .out_pix(out_pix),
    .out_eol(out_eol)
  );

  AST_GAP_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
    out_eol |=> !out_valid);  // R11
endmodule

// File: tb/vline_polyphase_scaler_tb_top.sv
module vline_polyphase_scaler_tb_top;
  import vlps_pkg::*;

  localparam int LW  = 4;
  localparam int OLW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, frame_start, in_valid, in_ready, in_eof;
  logic [PW-1:0] in_pix;
  logic cfg_five_tap, cfg_full_range, cfg_chroma;
  logic [STEP_W-1:0] cfg_step;
  logic [OLW-1:0] cfg_out_lines;
  logic [BANK_W-1:0] coef_luma, coef_chroma;
  logic out_valid, out_eol;
  logic [OW-1:0] out_pix;

  vline_polyphase_scaler #(.LINE_W(LW), .OUT_LINES_W(OLW)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .in_eof(in_eof),
    .cfg_five_tap(cfg_five_tap), .cfg_full_range(cfg_full_range),
    .cfg_chroma(cfg_chroma), .cfg_step(cfg_step), .cfg_out_lines(cfg_out_lines),
    .coef_luma(coef_luma), .coef_chroma(coef_chroma), .out_valid(out_valid),
    .out_pix(out_pix), .out_eol(out_eol)
  );

  int n_chk = 0;
  int n_err = 0;
  bit frame_done;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // raw coefficient byte for bank b, phase p, tap k
  function automatic int cbyte(int b, int p, int k);
    if (b == 0) return (p * 37 + k * 71 + 13) & 255;
    case (k)
      0:       return (256 - (p + 1)) & 255;
      1:       return 20 + 2 * p;
      2:       return 96 - 2 * p;
      3:       return 10 + p;
      default: return 3;
    endcase
  endfunction

  function automatic int pix(int seed, int l, int x);
    return (l * 53 + x * 91 + seed * 17 + 7) & 255;
  endfunction

  function automatic int model(int five, int full, int b, int nl, int seed,
                               int ctr, int frac, int x);
    int ph = (frac >> 7) & 7;
    int acc = 0;
    int r;
    for (int k = 0; k < 5; k++) begin
      int c, li;
      if (five == 0 && (k == 0 || k == 4)) continue;
      c = cbyte(b, ph, k);
      if (k != 2 && c >= 128) c = c - 256;
      li = ctr + k - 2;
      if (li < 0) li = 0;
      if (li > nl - 1) li = nl - 1;
      acc += c * pix(seed, li, x);
    end
    r = (acc + 16) >>> 5;
    if (full != 0) begin
      if (r < 0) r = 0;
      if (r > 1023) r = 1023;
    end else begin
      if (r < 64) r = 64;
      if (r > 960) r = 960;
    end
    return r;
  endfunction

  task automatic drive_frame(int seed, int nl);
    for (int l = 0; l < nl && !frame_done; l++) begin
      for (int x = 0; x < LW && !frame_done; x++) begin
        in_pix   = PW'(pix(seed, l, x));
        in_eof   = (l == nl - 1) && (x == LW - 1);
        in_valid = 1'b1;
        while (!in_ready && !frame_done) @(negedge clk);
        if (!frame_done) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic watch_frame(int five, int full, int b, int step, int nl,
                             int seed, int nout);
    int ctr = 0;
    int frac = 0;
    int idle_bad = 0;
    string tag;
    tag = $sformatf("R2 R5 R6 R7 R8 %s %s %s", five != 0 ? "R3" : "R4",
                    full != 0 ? "R9-full" : "R9-reduced", b != 0 ? "R10" : "R10-luma");
    for (int j = 0; j < nout; j++) begin
      for (int x = 0; x < LW; x++) begin
        int exp_v;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        exp_v = model(five, full, b, nl, seed, ctr, frac, x);
        chk(int'(out_pix) == exp_v, tag, int'(out_pix), exp_v);
        chk(out_eol == (x == LW - 1), "R11 eol", int'(out_eol), int'(x == LW - 1));
      end
      begin
        int s = frac + step;
        ctr  += s >> 10;
        frac  = s & 1023;
      end
    end
    frame_done = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (out_valid || in_ready) idle_bad++;
    end
    chk(idle_bad == 0, "R11 idle after last line", idle_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int steps [4] = '{384, 1024, 1408, 2047};
    int heights [3] = '{1, 3, 7};
    int seed = 0;
    rst = 1'b1;
    frame_start = 1'b0;
    in_valid = 1'b0;
    in_eof = 1'b0;
    in_pix = '0;
    cfg_five_tap = 1'b0;
    cfg_full_range = 1'b1;
    cfg_chroma = 1'b0;
    cfg_step = '0;
    cfg_out_lines = OLW'(5);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 5; k++) begin
          if (b == 0) coef_luma[(p * 5 + k) * 8 +: 8] = 8'(cbyte(0, p, k));
          else coef_chroma[(p * 5 + k) * 8 +: 8] = 8'(cbyte(1, p, k));
        end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!in_ready && !out_valid, "R1 idle after reset", int'(in_ready | out_valid), 0);

    for (int five = 0; five < 2; five++)
      for (int full = 0; full < 2; full++)
        for (int b = 0; b < 2; b++)
          for (int si = 0; si < 4; si++)
            for (int hi = 0; hi < 3; hi++) begin
              seed++;
              cfg_five_tap   = five[0];
              cfg_full_range = full[0];
              cfg_chroma     = b[0];
              cfg_step       = STEP_W'(steps[si]);
              frame_done     = 1'b0;
              @(negedge clk);
              frame_start = 1'b1;
              @(negedge clk);
              frame_start = 1'b0;
              fork
                drive_frame(seed, heights[hi]);
                watch_frame(five, full, b, steps[si], heights[hi], seed, 5);
              join
            end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule